// File: doc/BRIEF.md
# PWM-Gated Phase Input Sampler with Glitch Filter

This block conditions three slow position inputs from an incremental encoder or from Hall sensors before they reach an edge decoder. Each raw input first passes through two flip-flops. It is then sampled at a rate chosen from the system clock divided by 1, 2, 4 or 8. A level reaches the output only after it has been seen on a programmed number of consecutive samples, so short glitches never appear at the output.

When the motor is driven by PWM, switching noise is worst just after the bridge turns on and while it is off. In synchronous mode the block therefore samples only while the synchronized PWM-on signal is high. After every turn-on it skips a programmed number of sample ticks. As an option, it also wipes the stability counters while PWM is off, so that each on-window must prove the level again. In continuous mode the PWM signal is ignored.

Top module: `phase_glitch_filter`

## Requirements
- R1: While `rst` is high at a clock edge, every `filt_out` bit, every stability counter, the sample divider and the blanking counter become 0, and `filt_out` reads 0 in the cycle after that edge.
- R2: `raw_in` and `pwm_on` pass through two flip-flops. With `filt_len`=0, `div_sel`=00 and `sync_mode`=0, a change of `raw_in` driven before edge 1 appears on `filt_out` after edge 3 and not earlier.
- R3: A divider counter runs freely from reset. A sample tick occurs when its low bits are zero: `div_sel` 00 gives every cycle, 01 every 2nd cycle, 10 every 4th cycle and 11 every 8th cycle.
- R4: On each sample, a channel counts how many consecutive samples, including the present one, have held the present level. The count saturates at 127. The output takes the sampled level when that count is at least `filt_len`. Otherwise the output holds.
- R5: A sample that differs from the previous sample of the channel restarts its count at 1 (edge clear).
- R6: With `filt_len` of 0 or 1, the output takes the synchronized input on every sample (no filtering).
- R7: With `sync_mode`=0, every tick is a sample and `pwm_on` has no effect on `filt_out`.
- R8: With `sync_mode`=1, ticks are used only while the synchronized `pwm_on` is high.
- R9: With `sync_mode`=1, the cycle in which the synchronized `pwm_on` rises is not sampled, and the next `blank_len` ticks within the on-window are skipped.
- R10: With `sync_mode`=1 and `off_clear_en`=1, every stability counter is zeroed in each cycle where the synchronized `pwm_on` is low. With `off_clear_en`=0 the counts carry over into the next on-window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 3 | Raw phase inputs (A/B/Z or U/V/W) |
| pwm_on | input | 1 | Asynchronous PWM-on window from the motor driver |
| div_sel | input | 2 | Sample clock divider select (00=/1, 01=/2, 10=/4, 11=/8) |
| filt_len | input | 7 | Required number of stable samples |
| blank_len | input | 8 | Ticks skipped after each PWM turn-on |
| sync_mode | input | 1 | 1 = sample only inside the PWM-on window |
| off_clear_en | input | 1 | 1 = clear stability counters while PWM is off (sync mode) |
| filt_out | output | 3 | Registered filtered phase levels |

## Verification
The hardest case to reach from the ports is a level that built part of its count in one on-window and must finish the count after the blanking of the next one. With `off_clear_en` set, that level must start again from scratch. Reaching this needs `pwm_on` windows not much longer than `filt_len` times the divider, stacked on blanking. The bench sweeps every divider code against several filter lengths, both blanking values and both clear settings. It drives slow stretches of input, which build counts across window boundaries, alternating with glitch-dense stretches. A cycle-accurate model in the bench, computed from the requirements, is compared against the output on every cycle.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
  localparam int NUM_CH = 3;   // phase inputs
  localparam int FLT_W  = 7;   // stability length width
  localparam int BLK_W  = 8;   // blanking length width
  localparam int SEL_W  = 2;   // divider select width
endpackage

// File: rtl/pgf_sync.sv
module pgf_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pgf_tick.sv
module pgf_tick #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int DIVC_W = (1 << SEL_W) - 1;

  logic [DIVC_W-1:0] divc;
  logic [DIVC_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) divc <= '0;
    else     divc <= divc + DIVC_W'(1);
  end

  always_comb begin
    mask = (DIVC_W'(1) << div_sel) - DIVC_W'(1);
    tick = ((divc & mask) == '0);
  end
endmodule

// File: rtl/pgf_gate.sv
module pgf_gate #(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pwm_s,
  input  logic             sync_mode,
  input  logic             off_clear_en,
  input  logic [BLK_W-1:0] blank_len,
  output logic             samp_en,
  output logic             off_clr,
  output logic             blank_busy
);
  logic             pwm_q;
  logic [BLK_W-1:0] bcnt;
  logic             rise;

  always_comb begin
    rise       = pwm_s && !pwm_q;
    blank_busy = (bcnt != '0);
    samp_en    = tick && (!sync_mode || (pwm_s && !rise && !blank_busy));
    off_clr    = sync_mode && off_clear_en && !pwm_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
      bcnt  <= '0;
    end else begin
      pwm_q <= pwm_s;
      if (rise)
        bcnt <= blank_len;
      else if (tick && pwm_s && blank_busy)
        bcnt <= bcnt - BLK_W'(1);
    end
  end
endmodule

// File: rtl/pgf_chan.sv
module pgf_chan #(
  parameter int FLT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp,
  input  logic             clr,
  input  logic             din,
  input  logic [FLT_W-1:0] len,
  output logic             dout,
  output logic [FLT_W-1:0] cnt
);
  localparam logic [FLT_W-1:0] CNT_MAX = '1;

  logic             held;
  logic [FLT_W-1:0] nxt;

  always_comb begin
    if (din != held)        nxt = FLT_W'(1);
    else if (cnt == CNT_MAX) nxt = cnt;
    else                     nxt = cnt + FLT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
      cnt  <= '0;
      dout <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
    end else if (smp) begin
      held <= din;
      cnt  <= nxt;
      if (nxt >= len) dout <= din;
    end
  end
endmodule

// File: rtl/phase_glitch_filter.sv
module phase_glitch_filter
  import pgf_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int LEN_W  = FLT_W,
  parameter int BLNK_W = BLK_W,
  parameter int DSEL_W = SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   raw_in,
  input  logic              pwm_on,
  input  logic [DSEL_W-1:0] div_sel,
  input  logic [LEN_W-1:0]  filt_len,
  input  logic [BLNK_W-1:0] blank_len,
  input  logic              sync_mode,
  input  logic              off_clear_en,
  output logic [N_CH-1:0]   filt_out
);
  logic [N_CH-1:0]       in_s;
  logic                  pwm_s;
  logic                  tick;
  logic                  samp_en;
  logic                  off_clr;
  logic                  blank_busy;
  logic [N_CH*LEN_W-1:0] cnt_all;

  pgf_sync #(.W(N_CH + 1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pwm_on, raw_in}),
    .q   ({pwm_s, in_s})
  );

  pgf_tick #(.SEL_W(DSEL_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .div_sel (div_sel),
    .tick    (tick)
  );

  pgf_gate #(.BLK_W(BLNK_W)) u_gate (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .pwm_s        (pwm_s),
    .sync_mode    (sync_mode),
    .off_clear_en (off_clear_en),
    .blank_len    (blank_len),
    .samp_en      (samp_en),
    .off_clr      (off_clr),
    .blank_busy   (blank_busy)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pgf_chan #(.FLT_W(LEN_W)) u_chan (
      .clk  (clk),
      .rst  (rst),
      .smp  (samp_en),
      .clr  (off_clr),
      .din  (in_s[g]),
      .len  (filt_len),
      .dout (filt_out[g]),
      .cnt  (cnt_all[g*LEN_W +: LEN_W])
    );
  end
endmodule

// File: rtl/pgf_checker.sv
module pgf_checker #(
  parameter int N_CH   = 3,
  parameter int LEN_W  = 7,
  parameter int DSEL_W = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [DSEL_W-1:0]     div_sel,
  input logic [LEN_W-1:0]      filt_len,
  input logic                  sync_mode,
  input logic                  tick,
  input logic                  samp_en,
  input logic                  off_clr,
  input logic                  blank_busy,
  input logic                  pwm_s,
  input logic [N_CH-1:0]       in_s,
  input logic [N_CH*LEN_W-1:0] cnt_all,
  input logic [N_CH-1:0]       filt_out
);
  assert_tick_every_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (div_sel == '0) |-> tick);

  assert_tick_sparse_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && div_sel != '0) |=> !tick);

  assert_cont_ignores_pwm_R7: assert property (@(posedge clk) disable iff (rst)
    !sync_mode |-> (samp_en == tick));

  assert_gate_off_R8: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && !pwm_s) |-> !samp_en);

  assert_blank_R9: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && blank_busy) |-> !samp_en);

  assert_off_clear_R10: assert property (@(posedge clk) disable iff (rst)
    off_clr |=> (cnt_all == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !samp_en |=> $stable(filt_out));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    (samp_en && filt_len == '0) |=> (filt_out == $past(in_s)));
endmodule

bind phase_glitch_filter pgf_checker #(
  .N_CH(N_CH), .LEN_W(LEN_W), .DSEL_W(DSEL_W)
) u_pgf_checker (
  .clk        (clk),
  .rst        (rst),
  .div_sel    (div_sel),
  .filt_len   (filt_len),
  .sync_mode  (sync_mode),
  .tick       (tick),
  .samp_en    (samp_en),
  .off_clr    (off_clr),
  .blank_busy (blank_busy),
  .pwm_s      (pwm_s),
  .in_s       (in_s),
  .cnt_all    (cnt_all),
  .filt_out   (filt_out)
);

// File: tb/test_phase_glitch_filter.sv
module test_phase_glitch_filter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] raw_in = '0;
  logic       pwm_on = 1'b0;
  logic [1:0] div_sel = '0;
  logic [6:0] filt_len = '0;
  logic [7:0] blank_len = '0;
  logic       sync_mode = 1'b0;
  logic       off_clear_en = 1'b0;
  logic [2:0] filt_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;  // 250 MHz

  phase_glitch_filter i_phase_glitch_filter (
    .clk(clk), .rst(rst), .raw_in(raw_in), .pwm_on(pwm_on),
    .div_sel(div_sel), .filt_len(filt_len), .blank_len(blank_len),
    .sync_mode(sync_mode), .off_clear_en(off_clear_en), .filt_out(filt_out)
  );

  // Cycle model built from the requirements
  logic [2:0] m_s1, m_s2, m_samp, m_out;
  logic       m_p1, m_p2, m_pq;
  logic [2:0] m_div;
  logic [7:0] m_b;
  logic [6:0] m_cnt [3];

  always @(posedge clk) begin
    logic tk, rise, allow, clr;
    logic [2:0] mask;
    logic [6:0] nc;
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_samp = '0; m_out = '0;
      m_p1 = 0; m_p2 = 0; m_pq = 0; m_div = '0; m_b = '0;
      for (int i = 0; i < 3; i++) m_cnt[i] = '0;
    end else begin
      mask  = (3'd1 << div_sel) - 3'd1;
      tk    = ((m_div & mask) == 3'd0);
      rise  = m_p2 && !m_pq;
      allow = tk && (!sync_mode || (m_p2 && !rise && m_b == 8'd0));
      clr   = sync_mode && off_clear_en && !m_p2;
      for (int i = 0; i < 3; i++) begin
        if (clr) m_cnt[i] = '0;
        else if (allow) begin
          if (m_s2[i] != m_samp[i]) nc = 7'd1;
          else if (m_cnt[i] == 7'd127) nc = 7'd127;
          else nc = m_cnt[i] + 7'd1;
          if (nc >= filt_len) m_out[i] = m_s2[i];
          m_samp[i] = m_s2[i];
          m_cnt[i] = nc;
        end
      end
      if (rise) m_b = blank_len;
      else if (tk && m_p2 && m_b != 8'd0) m_b = m_b - 8'd1;
      m_pq = m_p2; m_p2 = m_p1; m_p1 = pwm_on;
      m_s2 = m_s1; m_s1 = raw_in;
      m_div = m_div + 3'd1;
    end
  end

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s filt_out=%b expected=%b", req, got, exp);
    end
  endtask

  // Advance one cycle; compare against the model at the falling edge
  task automatic step();
    @(negedge clk);
    cycles++;
    if (model_on) check(tag, filt_out, m_out);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step(); step();
    @(negedge clk);
    rst = 1'b0;
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    // R1: reset state
    do_reset();
    check("R1 reset", filt_out, 3'b000);

    // R2: two-flop synchronizer latency with no filtering
    filt_len = 0; div_sel = 0; sync_mode = 0;
    raw_in = 3'b000;
    for (int k = 0; k < 4; k++) step();
    raw_in = 3'b101;          // driven before edge 1
    step();                   // after edge 1
    step();                   // after edge 2
    check("R2 latency early", filt_out, 3'b000);
    step();                   // after edge 3
    check("R2 latency arrives", filt_out, 3'b101);

    // Sweep against the model
    for (int ds = 0; ds < 4; ds++)
      for (int ni = 0; ni < 4; ni++)
        for (int sm = 0; sm < 2; sm++)
          for (int oc = 0; oc < 2; oc++)
            for (int bl = 0; bl < 2; bl++) begin
              model_on = 1'b0;
              div_sel = 2'(ds);
              filt_len = (ni == 0) ? 7'd0 : (ni == 1) ? 7'd1 : (ni == 2) ? 7'd3 : 7'd5;
              sync_mode = sm[0];
              off_clear_en = oc[0];
              blank_len = bl[0] ? 8'd2 : 8'd0;
              raw_in = '0; pwm_on = 1'b0;
              if (sm == 0)        tag = (ni < 2) ? "R6 R7 R3" : "R4 R5 R7 R3";
              else if (oc == 1)   tag = "R10 R8 R9 R4";
              else                tag = "R8 R9 R4 R5";
              do_reset();
              model_on = 1'b1;
              for (int c = 0; c < 256; c++) begin
                bit glitchy;
                glitchy = c[6];
                lfsr = {lfsr[14:0], 1'b0} ^ (lfsr[15] ? 16'h1021 : 16'h0);
                for (int i = 0; i < 3; i++) begin
                  if (glitchy ? (lfsr[i*2 +: 2] == 2'd0) : (lfsr[i*5 +: 5] == 5'd0))
                    raw_in[i] = ~raw_in[i];
                end
                pwm_on = ((c % 48) < 30);
                step();
              end
            end
    model_on = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule